// File: doc/BRIEF.md
# Flush-Blocking Line Directory Controller

This block is the home-directory slice that services cache-line flushes for one line. When a cache asks to flush the line, the controller looks at the line's stable sharing state and picks a route. It may probe every other cache. It may send a directed probe to the current owner. If the requester already owns the line, it returns a block acknowledge to the requester. If home memory holds the data, it also starts a memory fetch.

From then on the line is locked. Every ordinary request is held in an in-order replay queue. The lock lasts until the flushing cache returns the line with a flush writeback and the memory write of that writeback completes. The controller then returns to the home-exclusive state and replays the held requests one per cycle.

Requests that are not flushes are handed on unchanged on a pass-through channel to the rest of the directory. The same holds for DMA requests that are allowed through the flush lock. The rest of the directory also writes the line's stable state, owner and sharer set through an update port.

Top module: `flushdir_ctrl`

## Requirements
- R1: After reset the line is in the home-exclusive state (state code 4), owner 0, sharer set empty, and every message valid output is low.
- R2: A flush request (type code 2) in the no-copy state (code 0) or shared state (code 2) emits, one cycle later, a broadcast probe (fwd_bcast=1) carrying the requester id. It clears the sharer set and enters the flush-locked state (code 5).
- R3: A flush request in the remote-owned state (code 1) from a cache other than the recorded owner emits one directed probe (fwd_bcast=0, fwd_dst=owner) and no block acknowledge, then enters state 5.
- R4: A flush request in state 1 from the recorded owner emits a block acknowledge to that owner and no probe, then enters state 5.
- R5: A flush request in the home-owned state (code 3) or home-exclusive state (code 4) emits a broadcast probe together with a memory fetch. The fetch carries an expected acknowledge count of 1 in state 3 and NCACHE-1 in state 4. The sharer set is cleared and the line enters the memory-wait state (code 6).
- R6: Memory data arriving in state 6 sends a data message to the requester that started the flush, one cycle later, and moves the line to state 5.
- R7: In state 5, request types read-shared (0), read-exclusive (1), flush (2), put (3) and evict (4) are held, and DMA read (5) and DMA write (6) pass. In state 6 and in the writeback state (code 7), types 0 to 6 are all held. A held request produces no output.
- R8: Held requests are replayed in arrival order, one per cycle, starting on the first edge after the line reaches a state that no longer holds them.
- R9: A flush writeback (type 7) in state 5 emits a writeback acknowledge to its sender one cycle later and enters state 7, even while the replay queue is non-empty.
- R10: An unblock in state 5 records its sender as owner and as the only sharer, and the line stays in state 5.
- R11: Writeback-done in state 7 returns the line to state 4.
- R12: A request that is neither held nor a flush it services appears one cycle later on the pass-through channel with its type and sender.
- R13: The update port loads state, owner and sharers only while the line is in a stable state (codes 0 to 4). It is ignored in states 5 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | Incoming request valid |
| req_typ | input | 3 | Request type code |
| req_src | input | ID_W | Requesting cache id |
| mem_vld | input | 1 | Memory read data returned |
| unblk_vld | input | 1 | Unblock from the new owner |
| unblk_src | input | ID_W | Sender of the unblock |
| wbd_vld | input | 1 | Writeback data written to memory |
| upd_vld | input | 1 | Stable-state update from the directory |
| upd_state | input | 3 | New stable state code |
| upd_owner | input | ID_W | New owner id |
| upd_shr | input | NCACHE | New sharer set |
| fwd_vld | output | 1 | Probe issued |
| fwd_bcast | output | 1 | 1: all caches but requester, 0: directed |
| fwd_dst | output | ID_W | Directed probe target |
| fwd_src | output | ID_W | Requester named in the probe |
| mrd_vld | output | 1 | Memory fetch issued |
| mrd_acks | output | ACK_W | Expected acknowledge count |
| bak_vld | output | 1 | Block acknowledge issued |
| bak_dst | output | ID_W | Block acknowledge target |
| dat_vld | output | 1 | Memory data sent to requester |
| dat_dst | output | ID_W | Data target |
| wak_vld | output | 1 | Writeback acknowledge issued |
| wak_dst | output | ID_W | Writeback acknowledge target |
| pas_vld | output | 1 | Request handed to the rest of the directory |
| pas_typ | output | 3 | Type of handed-on request |
| pas_src | output | ID_W | Sender of handed-on request |
| state_o | output | 3 | Current line state code |
| owner_o | output | ID_W | Recorded owner |
| shr_o | output | NCACHE | Recorded sharer set |

## Verification
Every message is registered, so a message is due on the first clock edge after the edge that accepts its stimulus. Held requests are different: they come out on the second and later edges after the edge that accepts writeback-done, one per edge. The driver stamps each expected message with the edge count at which it must appear. The monitor samples on the falling edge and matches the outputs in a fixed order against the head of the queue. A message that arrives early, late, or not at all breaks the match and is reported. State, owner and sharer values are checked on the falling edge that follows the edge applying the stimulus.

// File: rtl/flushdir_pkg.sv
package flushdir_pkg;

   typedef enum logic [2:0] {
      DS_NX   = 3'd0,
      DS_NO   = 3'd1,
      DS_SH   = 3'd2,
      DS_OW   = 3'd3,
      DS_EX   = 3'd4,
      DS_FBLK = 3'd5,
      DS_FMEM = 3'd6,
      DS_WBK  = 3'd7
   } dstate_e;

   typedef enum logic [2:0] {
      RQ_GETS  = 3'd0,
      RQ_GETX  = 3'd1,
      RQ_GETF  = 3'd2,
      RQ_PUT   = 3'd3,
      RQ_EVICT = 3'd4,
      RQ_DMARD = 3'd5,
      RQ_DMAWR = 3'd6,
      RQ_PUTF  = 3'd7
   } rqtype_e;

   function automatic logic is_stable(input dstate_e s);
      return s <= DS_EX;
   endfunction

endpackage

// File: rtl/flushdir_fifo.sv
module flushdir_fifo #(
   parameter int W     = 5,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   generate
      if ((DEPTH < 2) || ((DEPTH & (DEPTH - 1)) != 0)) begin : g_bad_depth
         $error("flushdir_fifo: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wp, rp;
   logic [PW:0]   cnt;
   logic          do_push, do_pop;

   assign empty   = (cnt == '0);
   assign full    = (cnt == (PW+1)'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rp];

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end
endmodule

// File: rtl/flushdir_stall.sv
module flushdir_stall
   import flushdir_pkg::*;
(
   input  dstate_e st,
   input  rqtype_e typ,
   output logic    stall
);
   logic coherent_rq;
   logic dma_rq;

   assign coherent_rq = (typ == RQ_GETS) || (typ == RQ_GETX) || (typ == RQ_GETF) ||
                        (typ == RQ_PUT)  || (typ == RQ_EVICT);
   assign dma_rq      = (typ == RQ_DMARD) || (typ == RQ_DMAWR);

   always_comb begin
      case (st)
         DS_FBLK:         stall = coherent_rq;
         DS_FMEM, DS_WBK: stall = coherent_rq || dma_rq;
         default:         stall = 1'b0;
      endcase
   end
endmodule

// File: rtl/flushdir_ctrl.sv
module flushdir_ctrl
   import flushdir_pkg::*;
#(
   parameter int NCACHE = 4,
   parameter int QDEPTH = 4,
   parameter int ID_W   = (NCACHE > 1) ? $clog2(NCACHE) : 1,
   parameter int ACK_W  = $clog2(NCACHE + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_vld,
   input  logic [2:0]        req_typ,
   input  logic [ID_W-1:0]   req_src,
   input  logic              mem_vld,
   input  logic              unblk_vld,
   input  logic [ID_W-1:0]   unblk_src,
   input  logic              wbd_vld,
   input  logic              upd_vld,
   input  logic [2:0]        upd_state,
   input  logic [ID_W-1:0]   upd_owner,
   input  logic [NCACHE-1:0] upd_shr,
   output logic              fwd_vld,
   output logic              fwd_bcast,
   output logic [ID_W-1:0]   fwd_dst,
   output logic [ID_W-1:0]   fwd_src,
   output logic              mrd_vld,
   output logic [ACK_W-1:0]  mrd_acks,
   output logic              bak_vld,
   output logic [ID_W-1:0]   bak_dst,
   output logic              dat_vld,
   output logic [ID_W-1:0]   dat_dst,
   output logic              wak_vld,
   output logic [ID_W-1:0]   wak_dst,
   output logic              pas_vld,
   output logic [2:0]        pas_typ,
   output logic [ID_W-1:0]   pas_src,
   output logic [2:0]        state_o,
   output logic [ID_W-1:0]   owner_o,
   output logic [NCACHE-1:0] shr_o
);
   localparam int EW = 3 + ID_W;

   generate
      if (NCACHE < 2) begin : g_bad_ncache
         $error("flushdir_ctrl: NCACHE must be at least 2");
      end
      if (ID_W < $clog2(NCACHE)) begin : g_bad_idw
         $error("flushdir_ctrl: ID_W too narrow for NCACHE");
      end
   endgenerate

   dstate_e             st, n_st;
   logic [ID_W-1:0]     own, n_own, trk, n_trk;
   logic [NCACHE-1:0]   shr, n_shr;

   // replay queue and dispatch head
   logic                q_push, q_pop, q_empty, q_full;
   logic [EW-1:0]       q_dout;
   logic                in_putf, use_q, head_vld, head_stall, go;
   rqtype_e             head_typ;
   logic [ID_W-1:0]     head_src;

   assign in_putf  = req_vld && (rqtype_e'(req_typ) == RQ_PUTF);
   assign use_q    = !q_empty && !in_putf;
   assign head_vld = use_q || req_vld;
   assign head_typ = use_q ? rqtype_e'(q_dout[EW-1:ID_W]) : rqtype_e'(req_typ);
   assign head_src = use_q ? q_dout[ID_W-1:0] : req_src;
   assign go       = head_vld && !head_stall;
   assign q_push   = req_vld && !in_putf && (!q_empty || head_stall);
   assign q_pop    = use_q && !head_stall;

   flushdir_stall u_stall (
      .st    (st),
      .typ   (head_typ),
      .stall (head_stall)
   );

   flushdir_fifo #(.W(EW), .DEPTH(QDEPTH)) u_replay (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (q_push),
      .din   ({req_typ, req_src}),
      .pop   (q_pop),
      .dout  (q_dout),
      .empty (q_empty),
      .full  (q_full)
   );

   // next-state and message decode
   logic              d_fwd, d_bcast, d_mrd, d_bak, d_dat, d_wak, d_pas;
   logic [ID_W-1:0]   d_fdst;
   logic [ACK_W-1:0]  d_acks;
   logic              flush_go;

   assign flush_go = go && is_stable(st) && (head_typ == RQ_GETF);

   always_comb begin
      n_st    = st;
      n_own   = own;
      n_shr   = shr;
      n_trk   = trk;
      d_fwd   = 1'b0;
      d_bcast = 1'b0;
      d_fdst  = '0;
      d_mrd   = 1'b0;
      d_acks  = '0;
      d_bak   = 1'b0;
      d_dat   = 1'b0;
      d_wak   = 1'b0;
      d_pas   = 1'b0;
      if (flush_go) begin
         n_shr = '0;
         case (st)
            DS_NO: begin
               n_st = DS_FBLK;
               if (head_src != own) begin
                  d_fwd  = 1'b1;
                  d_fdst = own;
               end else begin
                  d_bak = 1'b1;
               end
            end
            DS_OW, DS_EX: begin
               n_st    = DS_FMEM;
               n_trk   = head_src;
               d_fwd   = 1'b1;
               d_bcast = 1'b1;
               d_mrd   = 1'b1;
               d_acks  = (st == DS_OW) ? ACK_W'(1) : ACK_W'(NCACHE - 1);
            end
            default: begin
               n_st    = DS_FBLK;
               d_fwd   = 1'b1;
               d_bcast = 1'b1;
            end
         endcase
      end else if (go && (st == DS_FBLK) && (head_typ == RQ_PUTF)) begin
         d_wak = 1'b1;
         n_st  = DS_WBK;
      end else if (go) begin
         d_pas = 1'b1;
      end

      if (mem_vld && (st == DS_FMEM)) begin
         d_dat = 1'b1;
         n_st  = DS_FBLK;
      end
      if (unblk_vld && (st == DS_FBLK)) begin
         n_own            = unblk_src;
         n_shr            = '0;
         n_shr[unblk_src] = 1'b1;
      end
      if (wbd_vld && (st == DS_WBK)) begin
         n_st = DS_EX;
      end
      if (upd_vld && is_stable(st) && !flush_go && is_stable(dstate_e'(upd_state))) begin
         n_st  = dstate_e'(upd_state);
         n_own = upd_owner;
         n_shr = upd_shr;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= DS_EX;
         own       <= '0;
         shr       <= '0;
         trk       <= '0;
         fwd_vld   <= 1'b0;
         fwd_bcast <= 1'b0;
         fwd_dst   <= '0;
         fwd_src   <= '0;
         mrd_vld   <= 1'b0;
         mrd_acks  <= '0;
         bak_vld   <= 1'b0;
         bak_dst   <= '0;
         dat_vld   <= 1'b0;
         dat_dst   <= '0;
         wak_vld   <= 1'b0;
         wak_dst   <= '0;
         pas_vld   <= 1'b0;
         pas_typ   <= '0;
         pas_src   <= '0;
      end else begin
         st        <= n_st;
         own       <= n_own;
         shr       <= n_shr;
         trk       <= n_trk;
         fwd_vld   <= d_fwd;
         fwd_bcast <= d_bcast;
         fwd_dst   <= d_fdst;
         fwd_src   <= head_src;
         mrd_vld   <= d_mrd;
         mrd_acks  <= d_acks;
         bak_vld   <= d_bak;
         bak_dst   <= head_src;
         dat_vld   <= d_dat;
         dat_dst   <= trk;
         wak_vld   <= d_wak;
         wak_dst   <= head_src;
         pas_vld   <= d_pas;
         pas_typ   <= head_typ;
         pas_src   <= head_src;
      end
   end

   assign state_o = st;
   assign owner_o = own;
   assign shr_o   = shr;
endmodule

// File: rtl/flushdir_chk.sv
module flushdir_chk
   import flushdir_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       q_push,
   input logic       q_full,
   input logic       wbd_vld,
   input logic       fwd_vld,
   input logic       fwd_bcast,
   input logic       mrd_vld,
   input logic       bak_vld,
   input logic       dat_vld,
   input logic       wak_vld,
   input logic [2:0] state_o
);
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      !(q_push && q_full)); // R7

   AST_PROBE_OR_BACK: assert property (@(posedge clk) disable iff (!rst_n)
      !(fwd_vld && bak_vld)); // R4

   AST_FETCH_WITH_BCAST: assert property (@(posedge clk) disable iff (!rst_n)
      mrd_vld |-> (fwd_vld && fwd_bcast)); // R5

   AST_FETCH_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
      mrd_vld |-> (state_o == DS_FMEM)); // R5

   AST_DATA_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      dat_vld |-> (state_o == DS_FBLK)); // R6

   AST_WBACK_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      wak_vld |-> (state_o == DS_WBK)); // R9

   AST_WB_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == DS_WBK && wbd_vld) |=> (state_o == DS_EX)); // R11
endmodule

bind flushdir_ctrl flushdir_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .q_push    (q_push),
   .q_full    (q_full),
   .wbd_vld   (wbd_vld),
   .fwd_vld   (fwd_vld),
   .fwd_bcast (fwd_bcast),
   .mrd_vld   (mrd_vld),
   .bak_vld   (bak_vld),
   .dat_vld   (dat_vld),
   .wak_vld   (wak_vld),
   .state_o   (state_o)
);

// File: tb/flushdir_ctrl_tb.sv
`timescale 1ns/1ps
module flushdir_ctrl_tb;
   localparam int NC   = 4;
   localparam int IDW  = 2;
   localparam int ACKW = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic            req_vld = 0, mem_vld = 0, unblk_vld = 0, wbd_vld = 0, upd_vld = 0;
   logic [2:0]      req_typ = 0, upd_state = 0;
   logic [IDW-1:0]  req_src = 0, unblk_src = 0, upd_owner = 0;
   logic [NC-1:0]   upd_shr = 0;
   logic            fwd_vld, fwd_bcast, mrd_vld, bak_vld, dat_vld, wak_vld, pas_vld;
   logic [IDW-1:0]  fwd_dst, fwd_src, bak_dst, dat_dst, wak_dst, pas_src, owner_o;
   logic [ACKW-1:0] mrd_acks;
   logic [2:0]      pas_typ, state_o;
   logic [NC-1:0]   shr_o;

   flushdir_ctrl #(.NCACHE(NC), .QDEPTH(4)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_typ(req_typ), .req_src(req_src),
      .mem_vld(mem_vld), .unblk_vld(unblk_vld), .unblk_src(unblk_src), .wbd_vld(wbd_vld),
      .upd_vld(upd_vld), .upd_state(upd_state), .upd_owner(upd_owner), .upd_shr(upd_shr),
      .fwd_vld(fwd_vld), .fwd_bcast(fwd_bcast), .fwd_dst(fwd_dst), .fwd_src(fwd_src),
      .mrd_vld(mrd_vld), .mrd_acks(mrd_acks), .bak_vld(bak_vld), .bak_dst(bak_dst),
      .dat_vld(dat_vld), .dat_dst(dat_dst), .wak_vld(wak_vld), .wak_dst(wak_dst),
      .pas_vld(pas_vld), .pas_typ(pas_typ), .pas_src(pas_src),
      .state_o(state_o), .owner_o(owner_o), .shr_o(shr_o)
   );

   typedef struct {
      int    cyc;
      int    kind;
      int    a;
      int    b;
      string tag;
   } ev_t;

   ev_t exq[$];
   int  cyc = 0;
   int  n_chk = 0;
   int  n_fail = 0;
   bit  done = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // kinds: 0 probe, 1 fetch, 2 block ack, 3 data, 4 writeback ack, 5 pass-through
   task automatic expect_ev(input int kind, input int a, input int b, input string tag, input int d);
      ev_t e;
      e.cyc = cyc + d; e.kind = kind; e.a = a; e.b = b; e.tag = tag;
      exq.push_back(e);
   endtask

   task automatic observe(input logic vld, input int kind, input int a, input int b);
      if (vld) begin
         n_chk++;
         if (exq.size() == 0 || exq[0].cyc != cyc || exq[0].kind != kind ||
             exq[0].a != a || exq[0].b != b) begin
            n_fail++;
            if (exq.size() == 0)
               $display("FAIL unexpected: actual kind %0d a %0d b %0d at %0d expected none",
                        kind, a, b, cyc);
            else
               $display("FAIL %s: actual kind %0d a %0d b %0d at %0d expected kind %0d a %0d b %0d at %0d",
                        exq[0].tag, kind, a, b, cyc, exq[0].kind, exq[0].a, exq[0].b, exq[0].cyc);
            if (exq.size() != 0 && exq[0].cyc <= cyc) void'(exq.pop_front());
         end else begin
            void'(exq.pop_front());
         end
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         observe(fwd_vld, 0, int'(fwd_bcast), fwd_bcast ? int'(fwd_src) : int'(fwd_dst));
         observe(mrd_vld, 1, int'(mrd_acks), 0);
         observe(bak_vld, 2, int'(bak_dst), 0);
         observe(dat_vld, 3, int'(dat_dst), 0);
         observe(wak_vld, 4, int'(wak_dst), 0);
         observe(pas_vld, 5, int'(pas_typ), int'(pas_src));
         while (exq.size() != 0 && exq[0].cyc <= cyc) begin
            n_chk++;
            n_fail++;
            $display("FAIL %s: actual none expected kind %0d at %0d",
                     exq[0].tag, exq[0].kind, exq[0].cyc);
            void'(exq.pop_front());
         end
      end
   end

   task automatic step();
      @(posedge clk);
      @(negedge clk);
      req_vld = 0; mem_vld = 0; unblk_vld = 0; wbd_vld = 0; upd_vld = 0;
   endtask

   task automatic send(input int typ, input int src);
      req_vld = 1; req_typ = 3'(typ); req_src = IDW'(src);
      step();
   endtask

   task automatic upd(input int s, input int o, input int sh);
      upd_vld = 1; upd_state = 3'(s); upd_owner = IDW'(o); upd_shr = NC'(sh);
      step();
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic close_flush(input int src);
      expect_ev(4, src, 0, "R9 writeback ack", 1);
      send(7, src);
      check("R9 state WB", state_o, 7);
      wbd_vld = 1;
      step();
      check("R11 back to home-exclusive", state_o, 4);
   endtask

   initial begin
      fork
         begin
            repeat (20000) @(posedge clk);
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
         end
      join_none
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check("R1 reset state", state_o, 4);
      check("R1 reset owner", owner_o, 0);
      check("R1 reset sharers", shr_o, 0);
      check("R1 reset valids", int'({fwd_vld, mrd_vld, bak_vld, dat_vld, wak_vld, pas_vld}), 0);

      // flush from home-exclusive, with held traffic
      expect_ev(0, 1, 2, "R5 probe from E", 1);
      expect_ev(1, NC - 1, 0, "R5 fetch acks E", 1);
      send(2, 2);
      check("R5 memory-wait state", state_o, 6);
      send(0, 1);
      send(5, 3);
      check("R7 held in memory wait", state_o, 6);
      expect_ev(3, 2, 0, "R6 data to requester", 1);
      mem_vld = 1;
      step();
      check("R6 locked state", state_o, 5);
      unblk_vld = 1; unblk_src = 2;
      step();
      check("R10 owner", owner_o, 2);
      check("R10 sharers", shr_o, 4);
      check("R10 state kept", state_o, 5);
      expect_ev(4, 2, 0, "R9 writeback ack with queue", 1);
      send(7, 2);
      check("R9 state WB", state_o, 7);
      expect_ev(5, 0, 1, "R8 replay first", 2);
      expect_ev(5, 5, 3, "R8 replay second", 3);
      wbd_vld = 1;
      step();
      check("R11 back to home-exclusive", state_o, 4);
      idle(3);

      // no-copy state
      upd(0, 1, 0);
      check("R13 update to NX", state_o, 0);
      expect_ev(0, 1, 3, "R2 broadcast from NX", 1);
      send(2, 3);
      check("R2 locked", state_o, 5);
      close_flush(3);

      // shared state
      upd(2, 0, 3);
      check("R13 sharers loaded", shr_o, 3);
      expect_ev(0, 1, 0, "R2 broadcast from S", 1);
      send(2, 0);
      check("R2 sharers cleared", shr_o, 0);
      close_flush(0);

      // remote-owned, requester not owner
      upd(1, 1, 2);
      expect_ev(0, 0, 1, "R3 directed probe", 1);
      send(2, 2);
      check("R3 locked", state_o, 5);
      expect_ev(5, 6, 0, "R12 DMA passes lock", 1);
      send(6, 0);
      send(1, 0);
      upd(0, 3, 15);
      check("R13 update ignored state", state_o, 5);
      check("R13 update ignored owner", owner_o, 1);
      expect_ev(4, 2, 0, "R9 writeback ack", 1);
      send(7, 2);
      expect_ev(5, 1, 0, "R8 replay GETX", 2);
      wbd_vld = 1;
      step();
      check("R11 state", state_o, 4);
      idle(2);

      // remote-owned, requester is owner
      upd(1, 3, 8);
      expect_ev(2, 3, 0, "R4 block ack", 1);
      send(2, 3);
      check("R4 locked", state_o, 5);
      close_flush(3);

      // home-owned
      upd(3, 0, 6);
      expect_ev(0, 1, 1, "R5 probe from O", 1);
      expect_ev(1, 1, 0, "R5 fetch acks O", 1);
      send(2, 1);
      check("R5 O sharers cleared", shr_o, 0);
      check("R5 O memory wait", state_o, 6);
      expect_ev(3, 1, 0, "R6 data from O", 1);
      mem_vld = 1;
      step();
      close_flush(1);

      // non-flush traffic in stable state
      expect_ev(5, 1, 2, "R12 GETX pass", 1);
      send(1, 2);
      expect_ev(5, 3, 1, "R12 PUT pass", 1);
      send(3, 1);
      idle(3);
      check("R12 queue drained", exq.size(), 0);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule